// File: doc/BRIEF.md
# NAND Command and Address Decoder

This block is the device-side front end of a small-page NAND memory. It watches an 8-bit I/O bus with chip enable, write enable and two latch-select strobes. Each byte is taken on a rising edge of write enable while chip enable is low. The strobes then mark it as a command, an address or a data byte. Commands are turned into one-cycle operation requests. Operations that need an address gather it first, and the request carries the column byte, the assembled row and the column region in force.

The decoder runs multi-cycle sequences: read, program, copy-back and erase. It only accepts a confirm byte after the address phase it belongs to. It keeps the column-pointer region of the 528-byte page register: first half, second half or the 16-byte spare area. While the array reports busy, it drops every byte except the reset and status commands. The cell array, program and erase timing, and the read data path live in other blocks.

Top module: `nand_cmd_front`

## Requirements
- R1: A byte is taken only on a low-to-high transition of `we_n` while `ce_n` is low. With `ce_n` high, no request, illegal flag or data strobe appears.
- R2: A taken byte is a command when `cle` is high, even if `ale` is also high. It is an address when only `ale` is high. With both low it is data, and data raises `data_valid` for one cycle with the byte on `data_byte` and no request.
- R3: After 00h, 01h or 50h, four address bytes give a one-cycle request with `req_op`=1 (read). `req_col` is the first address byte. `req_row` is 18 bits: the second byte in bits 7:0, the third in bits 15:8 and bits 1:0 of the fourth in bits 17:16. No request appears before the fourth byte.
- R4: 00h, 01h and 50h set `ptr_region` to 0 (first half), 1 (second half) and 2 (spare), and the value is carried on `req_region`. After an addressed request is issued in region 1, `ptr_region` returns to 0. Region 2 stays until another region command or reset.
- R5: 80h plus four address bytes gives `req_op`=3 (program load). A following 10h gives `req_op`=5 (program run), and 11h gives `req_op`=6 (plane step).
- R6: 60h plus three address bytes gives `req_op`=7 with `req_col`=0 and the row built from those three bytes, low byte first. A following D0h gives `req_op`=8.
- R7: Copy-back: a completed read address followed by 03h gives `req_op`=2. 8Ah plus four address bytes gives `req_op`=4, and 10h or 11h then closes the sequence with 5 or 6.
- R8: A confirm byte (03h, 10h, 11h, D0h) that does not follow its matching address phase raises `cmd_illegal` and starts nothing.
- R9: Any command byte outside {00h, 01h, 03h, 10h, 11h, 50h, 60h, 70h, 71h, 80h, 8Ah, 90h, D0h, FFh} raises `cmd_illegal` for one cycle with no request.
- R10: While `busy` is high, only FFh, 70h and 71h are accepted. Every other command, address or data byte produces nothing and leaves a partly collected address unchanged.
- R11: A command byte received part-way through an address phase abandons the partial address. Decoding restarts from the new command.
- R12: 90h, FFh, 70h and 71h give requests 9, 10, 11 and 12 at once. FFh also returns `ptr_region` to 0 and drops any pending sequence.
- R13: After reset, `req_valid`, `cmd_illegal` and `data_valid` are low and `ptr_region` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, samples the bus strobes |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, byte taken on its rising edge |
| cle | input | 1 | Command latch select |
| ale | input | 1 | Address latch select |
| io_in | input | 8 | I/O bus byte |
| busy | input | 1 | Array busy indication |
| req_valid | output | 1 | One-cycle operation request |
| req_op | output | 4 | Operation code of the request |
| req_col | output | 8 | Column byte of the request |
| req_row | output | 18 | Assembled row address |
| req_region | output | 2 | Column region carried with the request |
| cmd_illegal | output | 1 | One-cycle flag for a rejected command |
| data_valid | output | 1 | One-cycle data byte strobe |
| data_byte | output | 8 | Data byte taken |
| ptr_region | output | 2 | Column region currently selected |

## Verification
The bench builds the block with its default three row bytes and an 18-bit row. That is small enough to sweep every one of the 256 command codes, both idle and busy. The read sweep runs several computed address patterns through all three region commands. At this size every sequence length, the dropped upper bits of the last row byte and each confirm-context case can be checked against arithmetic in the bench.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;

    typedef enum logic [1:0] {
        CYC_NONE = 2'd0,
        CYC_CMD  = 2'd1,
        CYC_ADDR = 2'd2,
        CYC_DATA = 2'd3
    } cyc_kind_e;

    typedef struct packed {
        cyc_kind_e   kind;
        logic [7:0]  val;
    } cyc_t;

    typedef enum logic [1:0] {
        RGN_FIRST  = 2'd0,
        RGN_SECOND = 2'd1,
        RGN_SPARE  = 2'd2
    } region_e;

    typedef enum logic [3:0] {
        OP_NONE       = 4'd0,
        OP_READ       = 4'd1,
        OP_COPY_READ  = 4'd2,
        OP_PROG_LOAD  = 4'd3,
        OP_COPY_LOAD  = 4'd4,
        OP_PROG_RUN   = 4'd5,
        OP_PROG_PLANE = 4'd6,
        OP_ERASE_ADDR = 4'd7,
        OP_ERASE_RUN  = 4'd8,
        OP_READ_ID    = 4'd9,
        OP_RESET      = 4'd10,
        OP_STATUS     = 4'd11,
        OP_MSTATUS    = 4'd12
    } op_e;

    // which addressed command owns the address phase
    typedef enum logic [1:0] {
        SEQ_READ  = 2'd0,
        SEQ_PROG  = 2'd1,
        SEQ_COPY  = 2'd2,
        SEQ_ERASE = 2'd3
    } seq_e;

    // which confirm byte is currently allowed
    typedef enum logic [1:0] {
        PEND_NONE  = 2'd0,
        PEND_READ  = 2'd1,
        PEND_PROG  = 2'd2,
        PEND_ERASE = 2'd3
    } pend_e;

    localparam logic [7:0] K_RD_LO    = 8'h00;
    localparam logic [7:0] K_RD_HI    = 8'h01;
    localparam logic [7:0] K_CB_RD    = 8'h03;
    localparam logic [7:0] K_PG_GO    = 8'h10;
    localparam logic [7:0] K_PG_PLN   = 8'h11;
    localparam logic [7:0] K_RD_SPR   = 8'h50;
    localparam logic [7:0] K_ER_SET   = 8'h60;
    localparam logic [7:0] K_STAT     = 8'h70;
    localparam logic [7:0] K_MSTAT    = 8'h71;
    localparam logic [7:0] K_PG_SET   = 8'h80;
    localparam logic [7:0] K_CB_DST   = 8'h8A;
    localparam logic [7:0] K_IDENT    = 8'h90;
    localparam logic [7:0] K_ER_GO    = 8'hD0;
    localparam logic [7:0] K_RESET    = 8'hFF;

    function automatic logic busy_pass(input logic [7:0] c);
        return (c == K_RESET) || (c == K_STAT) || (c == K_MSTAT);
    endfunction

endpackage

// File: rtl/nand_cycle_sorter.sv
module nand_cycle_sorter
    import nand_fe_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ce_n,
    input  logic       we_n,
    input  logic       cle,
    input  logic       ale,
    input  logic [7:0] io_in,
    output cyc_t       cyc
);

    logic we_q;

    always_ff @(posedge clk) begin
        if (rst) we_q <= 1'b1;
        else     we_q <= we_n;
    end

    // rising write enable with chip enable low takes one byte
    always_comb begin
        cyc.kind = CYC_NONE;
        cyc.val  = io_in;
        if (we_n && !we_q && !ce_n) begin
            if (cle)      cyc.kind = CYC_CMD;
            else if (ale) cyc.kind = CYC_ADDR;
            else          cyc.kind = CYC_DATA;
        end
    end

endmodule

// File: rtl/nand_addr_collector.sv
module nand_addr_collector #(
    parameter int ROW_BYTES = 3,
    parameter int ROW_W     = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             with_col,
    input  logic             clear,
    input  logic             take,
    input  logic [7:0]       byte_in,
    output logic             last,
    output logic [7:0]       col_o,
    output logic [ROW_W-1:0] row_o
);

    localparam int SW = $clog2(ROW_BYTES + 2);

    logic             active;
    logic             has_col_q;
    logic [SW-1:0]    cnt;
    logic [SW-1:0]    slot;
    logic [7:0]       col_q, col_n;
    logic [ROW_W-1:0] row_q, row_n;

    // slot 0 is the column byte, slot k is row byte k-1
    assign slot = has_col_q ? cnt : cnt + SW'(1);

    always_comb begin
        col_n = col_q;
        row_n = row_q;
        if (take && active) begin
            if (slot == '0) col_n = byte_in;
            for (int b = 0; b < ROW_W; b++) begin
                if (slot == SW'(b / 8 + 1)) row_n[b] = byte_in[b % 8];
            end
        end
    end

    assign last  = take && active && (slot == SW'(ROW_BYTES));
    assign col_o = col_n;
    assign row_o = row_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            has_col_q <= 1'b0;
            cnt       <= '0;
            col_q     <= '0;
            row_q     <= '0;
        end else if (start) begin
            active    <= 1'b1;
            has_col_q <= with_col;
            cnt       <= '0;
            col_q     <= '0;
            row_q     <= '0;
        end else if (clear) begin
            active    <= 1'b0;
        end else if (take && active) begin
            col_q <= col_n;
            row_q <= row_n;
            if (last) active <= 1'b0;
            else      cnt    <= cnt + SW'(1);
        end
    end

    // R3
    slot_range_chk: assert property (@(posedge clk) disable iff (rst)
        active |-> (slot <= SW'(ROW_BYTES)));

endmodule

// File: rtl/nand_cmd_front.sv
module nand_cmd_front
    import nand_fe_pkg::*;
#(
    parameter int ROW_BYTES = 3,
    parameter int ROW_W     = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce_n,
    input  logic             we_n,
    input  logic             cle,
    input  logic             ale,
    input  logic [7:0]       io_in,
    input  logic             busy,
    output logic             req_valid,
    output logic [3:0]       req_op,
    output logic [7:0]       req_col,
    output logic [ROW_W-1:0] req_row,
    output logic [1:0]       req_region,
    output logic             cmd_illegal,
    output logic             data_valid,
    output logic [7:0]       data_byte,
    output logic [1:0]       ptr_region
);

    cyc_t cyc;
    logic accept, is_cmd, is_addr, is_data;
    logic start, with_col, clear, last;
    logic [7:0]       a_col;
    logic [ROW_W-1:0] a_row;

    seq_e    seq_q, seq_n;
    pend_e   pend_q, pend_n;
    region_e rgn_q, rgn_n;
    logic    r_valid, r_ill;
    op_e     r_op;

    nand_cycle_sorter sorter_i (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n),
        .cle(cle), .ale(ale), .io_in(io_in), .cyc(cyc)
    );

    nand_addr_collector #(.ROW_BYTES(ROW_BYTES), .ROW_W(ROW_W)) coll_i (
        .clk(clk), .rst(rst), .start(start), .with_col(with_col),
        .clear(clear), .take(is_addr), .byte_in(cyc.val),
        .last(last), .col_o(a_col), .row_o(a_row)
    );

    // busy filter: only reset and status commands pass
    assign accept  = (cyc.kind != CYC_NONE) &&
                     (!busy || (cyc.kind == CYC_CMD && busy_pass(cyc.val)));
    assign is_cmd  = accept && (cyc.kind == CYC_CMD);
    assign is_addr = accept && (cyc.kind == CYC_ADDR);
    assign is_data = accept && (cyc.kind == CYC_DATA);

    always_comb begin
        seq_n    = seq_q;
        pend_n   = pend_q;
        rgn_n    = rgn_q;
        start    = 1'b0;
        with_col = 1'b0;
        clear    = 1'b0;
        r_valid  = 1'b0;
        r_ill    = 1'b0;
        r_op     = OP_NONE;
        if (is_cmd) begin
            clear  = 1'b1;
            pend_n = PEND_NONE;
            case (cyc.val)
                K_RD_LO:  begin start = 1'b1; with_col = 1'b1; seq_n = SEQ_READ; rgn_n = RGN_FIRST;  end
                K_RD_HI:  begin start = 1'b1; with_col = 1'b1; seq_n = SEQ_READ; rgn_n = RGN_SECOND; end
                K_RD_SPR: begin start = 1'b1; with_col = 1'b1; seq_n = SEQ_READ; rgn_n = RGN_SPARE;  end
                K_PG_SET: begin start = 1'b1; with_col = 1'b1; seq_n = SEQ_PROG; end
                K_CB_DST: begin start = 1'b1; with_col = 1'b1; seq_n = SEQ_COPY; end
                K_ER_SET: begin start = 1'b1; seq_n = SEQ_ERASE; end
                K_IDENT:  begin r_valid = 1'b1; r_op = OP_READ_ID; end
                K_RESET:  begin r_valid = 1'b1; r_op = OP_RESET; rgn_n = RGN_FIRST; end
                K_STAT:   begin r_valid = 1'b1; r_op = OP_STATUS; end
                K_MSTAT:  begin r_valid = 1'b1; r_op = OP_MSTATUS; end
                K_CB_RD:  begin
                    if (pend_q == PEND_READ) begin r_valid = 1'b1; r_op = OP_COPY_READ; end
                    else r_ill = 1'b1;
                end
                K_PG_GO, K_PG_PLN: begin
                    if (pend_q == PEND_PROG) begin
                        r_valid = 1'b1;
                        r_op    = (cyc.val == K_PG_GO) ? OP_PROG_RUN : OP_PROG_PLANE;
                    end else r_ill = 1'b1;
                end
                K_ER_GO:  begin
                    if (pend_q == PEND_ERASE) begin r_valid = 1'b1; r_op = OP_ERASE_RUN; end
                    else r_ill = 1'b1;
                end
                default:  r_ill = 1'b1;
            endcase
        end else if (is_addr && last) begin
            r_valid = 1'b1;
            case (seq_q)
                SEQ_READ:  begin r_op = OP_READ;       pend_n = PEND_READ;  end
                SEQ_PROG:  begin r_op = OP_PROG_LOAD;  pend_n = PEND_PROG;  end
                SEQ_COPY:  begin r_op = OP_COPY_LOAD;  pend_n = PEND_PROG;  end
                default:   begin r_op = OP_ERASE_ADDR; pend_n = PEND_ERASE; end
            endcase
            // a second-half access falls back to the first half
            if (seq_q != SEQ_ERASE && rgn_q == RGN_SECOND) rgn_n = RGN_FIRST;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q       <= SEQ_READ;
            pend_q      <= PEND_NONE;
            rgn_q       <= RGN_FIRST;
            req_valid   <= 1'b0;
            req_op      <= OP_NONE;
            req_col     <= '0;
            req_row     <= '0;
            req_region  <= '0;
            cmd_illegal <= 1'b0;
            data_valid  <= 1'b0;
            data_byte   <= '0;
        end else begin
            seq_q       <= seq_n;
            pend_q      <= pend_n;
            rgn_q       <= rgn_n;
            req_valid   <= r_valid;
            req_op      <= r_op;
            req_col     <= a_col;
            req_row     <= a_row;
            req_region  <= rgn_q;
            cmd_illegal <= r_ill;
            data_valid  <= is_data;
            if (is_data) data_byte <= cyc.val;
        end
    end

    assign ptr_region = rgn_q;

    // R9
    req_ill_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && cmd_illegal));

    // R10
    busy_filter_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && $past(busy)) |->
        (req_op == OP_RESET || req_op == OP_STATUS || req_op == OP_MSTATUS));

    // R10
    busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(busy) |-> (!cmd_illegal && !data_valid));

    // R3
    req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> !req_valid);

    // R4
    region_code_chk: assert property (@(posedge clk) disable iff (rst)
        ptr_region != 2'd3);

    // R6
    erase_col_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == OP_ERASE_ADDR) |-> (req_col == 8'd0));

endmodule

// File: tb/nand_cmd_front_tb.sv
module nand_cmd_front_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int RW = 18;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_n = 1'b0, we_n = 1'b1, cle = 1'b0, ale = 1'b0, busy = 1'b0;
    logic [7:0] io_in = 8'h00;
    logic req_valid, cmd_illegal, data_valid;
    logic [3:0] req_op;
    logic [7:0] req_col, data_byte;
    logic [RW-1:0] req_row;
    logic [1:0] req_region, ptr_region;

    int total = 0;
    int fails = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    nand_cmd_front dut_i (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .cle(cle), .ale(ale),
        .io_in(io_in), .busy(busy), .req_valid(req_valid), .req_op(req_op),
        .req_col(req_col), .req_row(req_row), .req_region(req_region),
        .cmd_illegal(cmd_illegal), .data_valid(data_valid),
        .data_byte(data_byte), .ptr_region(ptr_region)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // kind: 0 command, 1 address, 2 data, 3 command with ale also high
    task automatic put(input int kind, input logic [7:0] b);
        @(negedge clk);
        cle   = (kind == 0 || kind == 3);
        ale   = (kind == 1 || kind == 3);
        io_in = b;
        we_n  = 1'b0;
        @(negedge clk);
        we_n  = 1'b1;
        @(negedge clk);
    endtask

    task automatic put_addr4(input logic [7:0] c, input logic [7:0] b1,
                             input logic [7:0] b2, input logic [7:0] b3);
        put(1, c); put(1, b1); put(1, b2); put(1, b3);
    endtask

    function automatic int row_of(input int b1, input int b2, input int b3);
        return ((b3 & 3) << 16) | ((b2 & 255) << 8) | (b1 & 255);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R13 reset state
        chk("R13 req_valid", req_valid, 0);
        chk("R13 cmd_illegal", cmd_illegal, 0);
        chk("R13 data_valid", data_valid, 0);
        chk("R13 ptr_region", ptr_region, 0);

        // R1: chip enable high blocks capture
        ce_n = 1'b1;
        put(0, 8'h90);
        chk("R1 no req with ce_n high", req_valid, 0);
        put(0, 8'h33);
        chk("R1 no illegal with ce_n high", cmd_illegal, 0);
        put(2, 8'h5A);
        chk("R1 no data with ce_n high", data_valid, 0);
        ce_n = 1'b0;

        // R2: both strobes high counts as a command
        put(3, 8'h90);
        chk("R2 cle priority req", req_valid, 1);
        chk("R2 cle priority op", req_op, 9);

        // R9 R12 R8: every command code at idle
        for (int c = 0; c < 256; c++) begin
            int e_req, e_op, e_ill;
            e_req = 0; e_op = 0; e_ill = 0;
            case (c)
                8'h90: begin e_req = 1; e_op = 9;  end
                8'hFF: begin e_req = 1; e_op = 10; end
                8'h70: begin e_req = 1; e_op = 11; end
                8'h71: begin e_req = 1; e_op = 12; end
                8'h00, 8'h01, 8'h50, 8'h80, 8'h8A, 8'h60: ;
                default: e_ill = 1;
            endcase
            put(0, 8'(c));
            chk("R9 illegal flag", cmd_illegal, e_ill);
            chk("R12 immediate req", req_valid, e_req);
            if (e_req == 1) chk("R12 immediate op", req_op, e_op);
        end
        put(0, 8'hFF);

        // R3 R4: read address assembly in all regions
        for (int i = 0; i < 6; i++) begin
            for (int m = 0; m < 3; m++) begin
                int col, b1, b2, b3;
                logic [7:0] code;
                code = (m == 0) ? 8'h00 : (m == 1) ? 8'h01 : 8'h50;
                col = (i * 53 + 7) & 255;
                b1  = (i * 29 + 1) & 255;
                b2  = (i * 71 + 200) & 255;
                b3  = (i * 45 + 3) & 255;
                put(0, code);
                chk("R4 region select", ptr_region, m);
                put(1, 8'(col));
                chk("R3 no early req", req_valid, 0);
                put(1, 8'(b1));
                put(1, 8'(b2));
                chk("R3 no early req", req_valid, 0);
                put(1, 8'(b3));
                chk("R3 req", req_valid, 1);
                chk("R3 op", req_op, 1);
                chk("R3 col", req_col, col);
                chk("R3 row", req_row, row_of(b1, b2, b3));
                chk("R4 req region", req_region, m);
                chk("R4 region after", ptr_region, (m == 1) ? 0 : m);
            end
        end

        // R4 R12: spare persists, reset returns to first half
        put(0, 8'h50);
        put_addr4(8'h01, 8'h02, 8'h03, 8'h04);
        put(0, 8'h90);
        chk("R4 spare persists", ptr_region, 2);
        put(0, 8'hFF);
        chk("R12 reset region", ptr_region, 0);

        // R5 R2: program with data, then both confirms
        put(0, 8'h80);
        put_addr4(8'h11, 8'h22, 8'h33, 8'hFF);
        chk("R5 load op", req_op, 3);
        chk("R5 load row", req_row, row_of(8'h22, 8'h33, 8'hFF));
        for (int d = 0; d < 3; d++) begin
            put(2, 8'(d * 91 + 5));
            chk("R2 data strobe", data_valid, 1);
            chk("R2 data byte", data_byte, (d * 91 + 5) & 255);
            chk("R2 data no req", req_valid, 0);
        end
        put(0, 8'h10);
        chk("R5 run req", req_valid, 1);
        chk("R5 run op", req_op, 5);
        put(0, 8'h80);
        put_addr4(8'h00, 8'h01, 8'h00, 8'h00);
        put(0, 8'h11);
        chk("R5 plane op", req_op, 6);

        // R6 erase
        put(0, 8'h60);
        put(1, 8'hA5); put(1, 8'h5A);
        chk("R6 no early req", req_valid, 0);
        put(1, 8'hC7);
        chk("R6 erase addr op", req_op, 7);
        chk("R6 erase col", req_col, 0);
        chk("R6 erase row", req_row, row_of(8'hA5, 8'h5A, 8'hC7));
        put(0, 8'hD0);
        chk("R6 erase run op", req_op, 8);

        // R7 copy-back
        put(0, 8'h00);
        put_addr4(8'h10, 8'h20, 8'h30, 8'h01);
        put(0, 8'h03);
        chk("R7 copy read req", req_valid, 1);
        chk("R7 copy read op", req_op, 2);
        put(0, 8'h8A);
        put_addr4(8'h40, 8'h50, 8'h60, 8'h02);
        chk("R7 copy load op", req_op, 4);
        chk("R7 copy load col", req_col, 8'h40);
        put(0, 8'h11);
        chk("R7 copy close op", req_op, 6);

        // R8 confirms out of context
        put(0, 8'h80);
        put_addr4(8'h01, 8'h01, 8'h01, 8'h01);
        put(0, 8'hD0);
        chk("R8 D0 after program", cmd_illegal, 1);
        chk("R8 D0 no req", req_valid, 0);
        put(0, 8'h60);
        put(1, 8'h01); put(1, 8'h02); put(1, 8'h03);
        put(0, 8'h10);
        chk("R8 10 after erase", cmd_illegal, 1);
        put(0, 8'h60);
        put(1, 8'h01); put(1, 8'h02); put(1, 8'h03);
        put(0, 8'h03);
        chk("R8 03 after erase", cmd_illegal, 1);

        // R11 abort mid address
        put(0, 8'h00);
        put(1, 8'hEE); put(1, 8'hDD);
        put(0, 8'h60);
        put(1, 8'h12); put(1, 8'h34);
        chk("R11 no early req", req_valid, 0);
        put(1, 8'h02);
        chk("R11 restart op", req_op, 7);
        chk("R11 restart row", req_row, row_of(8'h12, 8'h34, 8'h02));
        put(0, 8'h80);
        put(1, 8'h01);
        put(0, 8'h90);
        put(1, 8'h02); put(1, 8'h03); put(1, 8'h04);
        chk("R11 stray address ignored", req_valid, 0);

        // R10 busy sweep over all commands
        busy = 1'b1;
        for (int c = 0; c < 256; c++) begin
            int e_req, e_op;
            e_req = 0; e_op = 0;
            if (c == 8'hFF) begin e_req = 1; e_op = 10; end
            if (c == 8'h70) begin e_req = 1; e_op = 11; end
            if (c == 8'h71) begin e_req = 1; e_op = 12; end
            put(0, 8'(c));
            chk("R10 busy req", req_valid, e_req);
            chk("R10 busy no illegal", cmd_illegal, 0);
            if (e_req == 1) chk("R10 busy op", req_op, e_op);
        end
        busy = 1'b0;

        // R10 partial address survives ignored bytes during busy
        put(0, 8'h00);
        put(1, 8'h77); put(1, 8'h88);
        busy = 1'b1;
        put(1, 8'h01); put(1, 8'h02); put(1, 8'h03); put(1, 8'h04);
        chk("R10 busy address ignored", req_valid, 0);
        put(2, 8'h99);
        chk("R10 busy data ignored", data_valid, 0);
        busy = 1'b0;
        put(1, 8'h99);
        chk("R10 no early req", req_valid, 0);
        put(1, 8'h03);
        chk("R10 resumed req", req_valid, 1);
        chk("R10 resumed col", req_col, 8'h77);
        chk("R10 resumed row", req_row, row_of(8'h88, 8'h99, 8'h03));

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule